// File: doc/BRIEF.md
# Integer ALU with 32-bit Word Variants

This block is the purely combinational arithmetic and logic unit of a 64-bit integer core. It takes two 64-bit operands `a` and `b` and a 5-bit operation select `op`, and produces a 64-bit result `y` in the same cycle. It has no clock and no state. The 64-bit operations are add, subtract, AND, OR, XOR, three shifts, and signed and unsigned set-less-than. A second group of word operations works on the low 32 bits of the operands and widens its 32-bit result by copying bit 31 into bits 63:32.

The unit takes no part in choosing operands. Register-immediate forms reach it with the immediate already placed on `b`, and they use the same codes as the register forms. Loading an upper immediate uses the pass-through code, which copies `b` to `y`. PC-relative and address arithmetic use the plain add code. Branch decisions are made in another block.

Top module: `alu64`

## Requirements
- R1: With `op`=0 (add), `y` = `a`+`b` modulo 2^64. With `op`=1 (subtract), `y` = `a`-`b` modulo 2^64.
- R2: `op`=2, 3 and 4 give the bitwise AND, OR and XOR of `a` and `b`.
- R3: `op`=5 shifts `a` left and `op`=6 shifts `a` right with zero fill. `op`=7 shifts `a` right and fills with copies of `a[63]`. The shift distance is `b[5:0]`.
- R4: `op`=8 returns 1 when `a` < `b` as two's-complement numbers and 0 otherwise. `op`=9 does the same with an unsigned comparison. Bits 63:1 of the result are always 0.
- R5: `op`=10 (word add) and `op`=11 (word subtract) compute `a[31:0]`±`b[31:0]` modulo 2^32. The 32-bit result is then sign-extended from its bit 31.
- R6: `op`=12, 13 and 14 shift `a[31:0]` left, right with zero fill, and right with fill from `a[31]`, by `b[4:0]`. The 32-bit result is then sign-extended from its bit 31.
- R7: `op`=15 (pass-through) returns `b` unchanged.
- R8: Every `op` code from 16 to 31 returns a result of zero.
- R9: Operand bits outside the field an operation uses have no effect on `y`. This covers `b[63:6]` for 64-bit shifts, `b[63:5]` for word shifts, and bits 63:32 of both operands for word operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 64 | First operand |
| b | input | 64 | Second operand (register value or immediate) |
| op | input | 5 | Operation select, codes as in R1 to R8 |
| y | output | 64 | Result |

## Verification
The checker holds a set of result properties whenever the matching code is present. Set-less-than always gives a 0 or 1 result. Every word result has bits 63:32 equal to bit 31. Pass-through equals `b`, and unused codes give zero. An AND result has no bit set that is clear in either operand. An add result minus `b` gives back `a`. Shift distances, fill values, signed and unsigned ordering at the extremes, wrap-around, and the fact that ignored operand bits have no effect need specific operand values. Only the bench's directed scenarios and its model-compared pseudo-random sweep can show those.

// File: rtl/alu64_pkg.sv
package alu64_pkg;

    localparam int XLEN    = 64;
    localparam int HALF    = XLEN / 2;
    localparam int SH_FULL = $clog2(XLEN);
    localparam int SH_WORD = $clog2(HALF);
    localparam int OP_W    = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_SUB   = 5'd1,
        OP_AND   = 5'd2,
        OP_OR    = 5'd3,
        OP_XOR   = 5'd4,
        OP_SLL   = 5'd5,
        OP_SRL   = 5'd6,
        OP_SRA   = 5'd7,
        OP_SLT   = 5'd8,
        OP_SLTU  = 5'd9,
        OP_ADDW  = 5'd10,
        OP_SUBW  = 5'd11,
        OP_SLLW  = 5'd12,
        OP_SRLW  = 5'd13,
        OP_SRAW  = 5'd14,
        OP_PASSB = 5'd15
    } alu_op_e;

    typedef struct packed {
        logic [XLEN-1:0] sum;
        logic [XLEN-1:0] diff;
        logic            lt_s;
        logic            lt_u;
    } arith_res_t;

    typedef struct packed {
        logic [XLEN-1:0] sll;
        logic [XLEN-1:0] srl;
        logic [XLEN-1:0] sra;
        logic [HALF-1:0] sllw;
        logic [HALF-1:0] srlw;
        logic [HALF-1:0] sraw;
    } shift_res_t;

    typedef struct packed {
        logic [XLEN-1:0] v_and;
        logic [XLEN-1:0] v_or;
        logic [XLEN-1:0] v_xor;
    } logic_res_t;

    function automatic logic [XLEN-1:0] widen_word(input logic [HALF-1:0] w);
        return {{(XLEN-HALF){w[HALF-1]}}, w};
    endfunction

    function automatic logic [XLEN-1:0] flag_to_word(input logic f);
        return {{(XLEN-1){1'b0}}, f};
    endfunction

endpackage

// File: rtl/alu64_arith.sv
module alu64_arith
    import alu64_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output arith_res_t      res
);
    always_comb begin
        res.sum  = a + b;
        res.diff = a - b;
        res.lt_s = $signed(a) < $signed(b);
        res.lt_u = a < b;
    end
endmodule

// File: rtl/alu64_logic.sv
module alu64_logic
    import alu64_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic_res_t      res
);
    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        assign res.v_and[i] = a[i] & b[i];
        assign res.v_or[i]  = a[i] | b[i];
        assign res.v_xor[i] = a[i] ^ b[i];
    end
endmodule

// File: rtl/alu64_shift.sv
module alu64_shift
    import alu64_pkg::*;
(
    input  logic [XLEN-1:0]    a,
    input  logic [SH_FULL-1:0] shamt,
    output shift_res_t         res
);
    logic [HALF-1:0]    lo;
    logic [SH_WORD-1:0] sh_w;

    assign lo   = a[HALF-1:0];
    assign sh_w = shamt[SH_WORD-1:0];

    always_comb begin
        res.sll  = a << shamt;
        res.srl  = a >> shamt;
        res.sra  = $signed(a) >>> shamt;
        res.sllw = lo << sh_w;
        res.srlw = lo >> sh_w;
        res.sraw = $signed(lo) >>> sh_w;
    end
endmodule

// File: rtl/alu64.sv
module alu64
    import alu64_pkg::*;
(
    input  logic [63:0] a,
    input  logic [63:0] b,
    input  logic [4:0]  op,
    output logic [63:0] y
);
    arith_res_t ar;
    logic_res_t lr;
    shift_res_t sr;
    alu_op_e    sel;

    assign sel = alu_op_e'(op);

    alu64_arith u_arith (.a(a), .b(b), .res(ar));
    alu64_logic u_logic (.a(a), .b(b), .res(lr));
    alu64_shift u_shift (.a(a), .shamt(b[SH_FULL-1:0]), .res(sr));

    always_comb begin
        case (sel)
            OP_ADD:   y = ar.sum;
            OP_SUB:   y = ar.diff;
            OP_AND:   y = lr.v_and;
            OP_OR:    y = lr.v_or;
            OP_XOR:   y = lr.v_xor;
            OP_SLL:   y = sr.sll;
            OP_SRL:   y = sr.srl;
            OP_SRA:   y = sr.sra;
            OP_SLT:   y = flag_to_word(ar.lt_s);
            OP_SLTU:  y = flag_to_word(ar.lt_u);
            OP_ADDW:  y = widen_word(ar.sum[HALF-1:0]);
            OP_SUBW:  y = widen_word(ar.diff[HALF-1:0]);
            OP_SLLW:  y = widen_word(sr.sllw);
            OP_SRLW:  y = widen_word(sr.srlw);
            OP_SRAW:  y = widen_word(sr.sraw);
            OP_PASSB: y = b;
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/alu64_chk.sv
module alu64_chk (
    input logic [63:0] a,
    input logic [63:0] b,
    input logic [4:0]  op,
    input logic [63:0] y
);
    always_comb begin
        // R1
        add_inverse_chk: assert (!(op == 5'd0) || (y - b == a));
        // R2
        and_subset_chk: assert (!(op == 5'd2) || (((y & ~a) == 64'd0) && ((y & ~b) == 64'd0)));
        // R4
        slt_bool_chk: assert (!(op == 5'd8 || op == 5'd9) || (y[63:1] == 63'd0));
        // R5
        word_arith_ext_chk: assert (!(op == 5'd10 || op == 5'd11) || (y[63:32] == {32{y[31]}}));
        // R6
        word_shift_ext_chk: assert (!(op >= 5'd12 && op <= 5'd14) || (y[63:32] == {32{y[31]}}));
        // R7
        passb_chk: assert (!(op == 5'd15) || (y == b));
        // R8
        undef_zero_chk: assert (!(op >= 5'd16) || (y == 64'd0));
    end
endmodule

bind alu64 alu64_chk chk_i (.a(a), .b(b), .op(op), .y(y));

// File: tb/alu64_tb_top.sv
module alu64_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    logic [4:0]  op = 5'd16;
    logic [63:0] y;
    int          errors = 0;
    int          checks = 0;
    logic [63:0] lfsr_a = 64'h9E37_79B9_7F4A_7C15;
    logic [63:0] lfsr_b = 64'hC2B2_AE3D_27D4_EB4F;

    always #10 clk = ~clk;

    alu64 dut_i (.a(a), .b(b), .op(op), .y(y));

    function automatic logic [63:0] sx32(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    function automatic logic [63:0] model(input logic [4:0] o, input logic [63:0] x,
                                          input logic [63:0] z);
        logic [31:0] xl;
        xl = x[31:0];
        case (o)
            5'd0:  return x + z;
            5'd1:  return x - z;
            5'd2:  return x & z;
            5'd3:  return x | z;
            5'd4:  return x ^ z;
            5'd5:  return x << z[5:0];
            5'd6:  return x >> z[5:0];
            5'd7:  return $signed(x) >>> z[5:0];
            5'd8:  return ($signed(x) < $signed(z)) ? 64'd1 : 64'd0;
            5'd9:  return (x < z) ? 64'd1 : 64'd0;
            5'd10: return sx32(xl + z[31:0]);
            5'd11: return sx32(xl - z[31:0]);
            5'd12: return sx32(xl << z[4:0]);
            5'd13: return sx32(xl >> z[4:0]);
            5'd14: return sx32($signed(xl) >>> z[4:0]);
            5'd15: return z;
            default: return 64'd0;
        endcase
    endfunction

    task automatic apply(input logic [4:0] o, input logic [63:0] x, input logic [63:0] z);
        @(negedge clk);
        op = o; a = x; b = z;
        #2;
    endtask

    task automatic check(input string req, input logic [63:0] exp);
        checks++;
        if (y !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", req, op, a, b, y, exp);
        end
    endtask

    task automatic run(input string req, input logic [4:0] o, input logic [63:0] x,
                       input logic [63:0] z, input logic [63:0] exp);
        apply(o, x, z);
        check(req, exp);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        apply(5'd16, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R8 reset-state undefined code", 64'd0);
    endtask

    task automatic t_arith_r1;
        run("R1 add", 5'd0, 64'd5, 64'd7, 64'd12);
        run("R1 add wrap", 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0);
        run("R1 sub", 5'd1, 64'd3, 64'd5, 64'hFFFF_FFFF_FFFF_FFFE);
        run("R1 sub min", 5'd1, 64'h8000_0000_0000_0000, 64'd1, 64'h7FFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_logic_r2;
        run("R2 and", 5'd2, 64'hF0F0_1234_0000_FFFF, 64'hFF00_FFFF_FFFF_0F0F, 64'hF000_1234_0000_0F0F);
        run("R2 or",  5'd3, 64'hF0F0_0000_0000_0000, 64'h0F00_0000_0000_0001, 64'hFFF0_0000_0000_0001);
        run("R2 xor", 5'd4, 64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_0000_FFFF_0000, 64'h5555_AAAA_5555_AAAA);
    endtask

    task automatic t_shift_r3;
        run("R3 sll 63", 5'd5, 64'd1, 64'd63, 64'h8000_0000_0000_0000);
        run("R3 srl 4", 5'd6, 64'h8000_0000_0000_0000, 64'd4, 64'h0800_0000_0000_0000);
        run("R3 sra 4", 5'd7, 64'h8000_0000_0000_0000, 64'd4, 64'hF800_0000_0000_0000);
        run("R3 sra positive", 5'd7, 64'h4000_0000_0000_0000, 64'd62, 64'd1);
        run("R3 shift 0", 5'd6, 64'h1234_5678_9ABC_DEF0, 64'd0, 64'h1234_5678_9ABC_DEF0);
        // R9: b[63:6] ignored, distance 0x41 -> 1
        run("R9 sll upper b ignored", 5'd5, 64'd1, 64'hFFFF_FFFF_FFFF_FFC1, 64'd2);
    endtask

    task automatic t_compare_r4;
        run("R4 slt -1<1", 5'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd1);
        run("R4 sltu -1<1", 5'd9, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0);
        run("R4 slt equal", 5'd8, 64'd9, 64'd9, 64'd0);
        run("R4 sltu 0<max", 5'd9, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
        run("R4 slt min<max", 5'd8, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1);
    endtask

    task automatic t_word_arith_r5;
        run("R5 addw overflow", 5'd10, 64'h0000_0000_7FFF_FFFF, 64'd1, 64'hFFFF_FFFF_8000_0000);
        run("R5 subw", 5'd11, 64'd0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        // R9: upper halves of both operands ignored
        run("R9 addw upper ignored", 5'd10, 64'hDEAD_BEEF_0000_0002, 64'h1234_5678_0000_0003, 64'd5);
    endtask

    task automatic t_word_shift_r6;
        run("R6 sllw into bit31", 5'd12, 64'd1, 64'd31, 64'hFFFF_FFFF_8000_0000);
        run("R6 srlw zero fill", 5'd13, 64'hFFFF_FFFF_8000_0000, 64'd4, 64'h0000_0000_0800_0000);
        run("R6 sraw sign fill", 5'd14, 64'h0000_0000_8000_0000, 64'd4, 64'hFFFF_FFFF_F800_0000);
        run("R6 srlw by 0 sign", 5'd13, 64'h0000_0000_8000_0000, 64'd0, 64'hFFFF_FFFF_8000_0000);
        // R9: b[5] ignored in word shift, distance 0x25 -> 5
        run("R9 sllw b5 ignored", 5'd12, 64'd1, 64'd37, 64'd32);
    endtask

    task automatic t_pass_r7;
        run("R7 pass-through", 5'd15, 64'h1111_2222_3333_4444, 64'hABCD_EF01_2345_6789, 64'hABCD_EF01_2345_6789);
    endtask

    task automatic t_undef_r8;
        for (int c = 16; c < 32; c++)
            run("R8 undefined code", 5'(c), 64'hFFFF_0000_FFFF_0000, 64'h0000_FFFF_0000_FFFF, 64'd0);
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 400; i++) begin
            lfsr_a = {lfsr_a[62:0], lfsr_a[63] ^ lfsr_a[62] ^ lfsr_a[60] ^ lfsr_a[59]};
            lfsr_b = {lfsr_b[62:0], lfsr_b[63] ^ lfsr_b[62] ^ lfsr_b[60] ^ lfsr_b[59]};
            apply(5'(i % 32), lfsr_a ^ {lfsr_b[31:0], lfsr_b[63:32]}, lfsr_b);
            check("R1-sweep model compare", model(op, a, b));
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_arith_r1();
        t_logic_r2();
        t_shift_r3();
        t_compare_r4();
        t_word_arith_r5();
        t_word_shift_r6();
        t_pass_r7();
        t_undef_r8();
        t_sweep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule